// File: doc/BRIEF.md
# Programmable CRC Register Unit

A register-mapped CRC engine on a simple 32-bit bus with byte strobes. Software sets a 32-bit generator polynomial and a 32-bit seed. It then issues a restart command that copies the seed into the running checksum. After that it streams data into the data register, either as full words or as single bytes. The running checksum is updated MSB-first and can be read back at any time.

Incoming data can be bit-reversed per byte, per halfword or across the whole word before it is folded in. The value read back can also be reversed. With these options the same engine produces reflected checksums such as CRC-32 and CRC-32C. The final inversion that those standards apply is left to software.

Every data write takes effect on the clock edge on which it is presented, so writes can arrive back to back. Bus reads are combinational and have no side effects.

Top module: `crc_mmio_unit`

## Requirements
- R1: After system reset the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0, and the data register reads 0xFFFFFFFF.
- R2: Byte offsets 0x00 (data), 0x08 (control), 0x10 (seed) and 0x14 (polynomial) are decoded. The seed and polynomial registers update only the byte lanes whose strobe is set and read back what was written. Any other offset reads 0.
- R3: A control write with strobe 0 set and bit 0 set loads the seed into the running checksum on that edge. Bit 0 always reads back as 0.
- R4: A data write with all four strobes set folds 32 bits into the checksum MSB-first. For each bit from 31 down to 0, feedback = crc[31] XOR d. Then crc = (crc << 1) XOR (feedback ? poly : 0).
- R5: A data write with exactly one strobe set folds the 8 bits of that lane (lane k = wdata[8k+7:8k]) in the same way, bit 7 first. A data write with any other strobe pattern leaves the checksum unchanged.
- R6: Control bits 6:5 select the input shaping for word writes: 00 none, 01 reverse within each byte, 10 reverse within each 16-bit half, 11 reverse the whole word. For byte writes, any value other than 00 reverses the 8 bits of the byte.
- R7: Control bit 7 set makes the data register read return the checksum with all 32 bits reversed. Cleared, the data register returns the checksum as is. The control register reads back bits 7:5 as written.
- R8: A control write with bit 0 clear changes the shaping and output settings but leaves the running checksum unchanged.
- R9: The polynomial is fully programmable. With seed 0xFFFFFFFF, byte reversal on input, output reversal and an inverted result, "123456789" gives 0xCBF43926 under 0x04C11DB7 and 0xE3069283 under 0x1EDC6F41.
- R10: Data writes on consecutive cycles are each folded in, with no wait states.
- R11: Right after a restart command with no data written, the data register returns the seed as seen through the output-reversal setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_be | input | 4 | Byte strobes, bit k covers wdata[8k+7:8k] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |

## Verification
The bench builds the unit with its default 32-bit checksum, 8-bit lanes and 5-bit offsets. At this size every input shaping mode can be crossed with both output settings, and with a fresh random polynomial for each combination. Each pass exercises all four byte lanes, full-word writes and several rejected strobe patterns against a bit-serial model. Two published check values confirm that the reversal options combine into standard reflected checksums.

// File: rtl/crcu_pkg.sv
package crcu_pkg;
    localparam int CRC_W  = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = CRC_W / LANE_W;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFS_DATA = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SEED = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_POLY = 5'h14;

    localparam logic [CRC_W-1:0] SEED_RST = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] POLY_RST = 32'h04C1_1DB7;

    localparam int CTL_RESTART = 0;
    localparam int CTL_MODE_LO = 5;
    localparam int CTL_OUT_REV = 7;

    typedef enum logic [1:0] {
        IN_PLAIN    = 2'b00,
        IN_REV_BYTE = 2'b01,
        IN_REV_HALF = 2'b10,
        IN_REV_WORD = 2'b11
    } in_shape_e;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CRC_W-1:0] seed;
        logic [CRC_W-1:0] poly;
        in_shape_e        shape;
        logic             out_rev;
    } crcu_state_t;
endpackage

// File: rtl/crcu_group_rev.sv
module crcu_group_rev #(
    parameter int WIDTH = 32,
    parameter int GROUP = 8
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NGRP = WIDTH / GROUP;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar b = 0; b < GROUP; b++) begin : g_bit
            assign dout[g*GROUP + b] = din[g*GROUP + GROUP - 1 - b];
        end
    end
endmodule

// File: rtl/crcu_fold.sv
module crcu_fold #(
    parameter int CRC_W = 32,
    parameter int STEPS = 32
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [CRC_W-1:0] poly,
    input  logic [STEPS-1:0] din,
    output logic [CRC_W-1:0] crc_out
);
    logic [STEPS:0][CRC_W-1:0] chain;

    assign chain[0] = crc_in;

    // one shift-and-reduce stage per data bit, MSB first
    for (genvar s = 0; s < STEPS; s++) begin : g_step
        logic fb;
        assign fb = chain[s][CRC_W-1] ^ din[STEPS-1-s];
        assign chain[s+1] = {chain[s][CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    end

    assign crc_out = chain[STEPS];
endmodule

// File: rtl/crc_mmio_unit.sv
module crc_mmio_unit
    import crcu_pkg::*;
#(
    parameter int DW   = CRC_W,
    parameter int LW   = LANE_W,
    parameter int AW   = ADDR_W,
    localparam int BEW = DW / LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [BEW-1:0] bus_be,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata
);
    crcu_state_t st_d, st_q;

    logic          wr_hit;
    logic          data_wr, ctrl_wr, seed_wr, poly_wr;
    logic          word_full, byte_hit;
    logic [DW-1:0] rev8_w, rev16_w, rev32_w, crc_rev;
    logic [DW-1:0] word_shaped, byte_src;
    logic [LW-1:0] lane_byte;
    logic [DW-1:0] word_next, byte_next;

    assign wr_hit  = bus_sel & bus_wr;
    assign data_wr = wr_hit & (bus_addr == OFS_DATA);
    assign ctrl_wr = wr_hit & (bus_addr == OFS_CTRL) & bus_be[0];
    assign seed_wr = wr_hit & (bus_addr == OFS_SEED);
    assign poly_wr = wr_hit & (bus_addr == OFS_POLY);
    assign word_full = &bus_be;

    crcu_group_rev #(.WIDTH(DW), .GROUP(LW))   u_rev8  (.din(bus_wdata), .dout(rev8_w));
    crcu_group_rev #(.WIDTH(DW), .GROUP(2*LW)) u_rev16 (.din(bus_wdata), .dout(rev16_w));
    crcu_group_rev #(.WIDTH(DW), .GROUP(DW))   u_rev32 (.din(bus_wdata), .dout(rev32_w));
    crcu_group_rev #(.WIDTH(DW), .GROUP(DW))   u_revo  (.din(st_q.crc), .dout(crc_rev));

    always_comb begin
        unique case (st_q.shape)
            IN_REV_BYTE: word_shaped = rev8_w;
            IN_REV_HALF: word_shaped = rev16_w;
            IN_REV_WORD: word_shaped = rev32_w;
            default:     word_shaped = bus_wdata;
        endcase
    end

    assign byte_src = (st_q.shape == IN_PLAIN) ? bus_wdata : rev8_w;

    always_comb begin
        byte_hit  = 1'b0;
        lane_byte = '0;
        for (int i = 0; i < BEW; i++) begin
            if (bus_be == (BEW'(1) << i)) begin
                byte_hit  = 1'b1;
                lane_byte = byte_src[i*LW +: LW];
            end
        end
    end

    crcu_fold #(.CRC_W(DW), .STEPS(DW)) u_fold_word (
        .crc_in(st_q.crc), .poly(st_q.poly), .din(word_shaped), .crc_out(word_next)
    );
    crcu_fold #(.CRC_W(DW), .STEPS(LW)) u_fold_byte (
        .crc_in(st_q.crc), .poly(st_q.poly), .din(lane_byte), .crc_out(byte_next)
    );

    always_comb begin
        st_d = st_q;
        if (data_wr && word_full) begin
            st_d.crc = word_next;
        end else if (data_wr && byte_hit) begin
            st_d.crc = byte_next;
        end
        if (ctrl_wr) begin
            st_d.shape   = in_shape_e'(bus_wdata[CTL_MODE_LO +: 2]);
            st_d.out_rev = bus_wdata[CTL_OUT_REV];
            if (bus_wdata[CTL_RESTART]) begin
                st_d.crc = st_q.seed;
            end
        end
        for (int i = 0; i < BEW; i++) begin
            if (seed_wr && bus_be[i]) st_d.seed[i*LW +: LW] = bus_wdata[i*LW +: LW];
            if (poly_wr && bus_be[i]) st_d.poly[i*LW +: LW] = bus_wdata[i*LW +: LW];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc     <= SEED_RST;
            st_q.seed    <= SEED_RST;
            st_q.poly    <= POLY_RST;
            st_q.shape   <= IN_PLAIN;
            st_q.out_rev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_DATA: bus_rdata = st_q.out_rev ? crc_rev : st_q.crc;
            OFS_CTRL: begin
                bus_rdata[CTL_MODE_LO +: 2] = st_q.shape;
                bus_rdata[CTL_OUT_REV]      = st_q.out_rev;
            end
            OFS_SEED: bus_rdata = st_q.seed;
            OFS_POLY: bus_rdata = st_q.poly;
            default:  bus_rdata = '0;
        endcase
    end

    assert_restart_loads_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CTL_RESTART]) |=> (st_q.crc == $past(st_q.seed)));

    assert_cfg_keeps_crc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[CTL_RESTART]) |=> (st_q.crc == $past(st_q.crc)));

    assert_bad_strobe_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !word_full && ($countones(bus_be) != 1)) |=> $stable(st_q.crc));

    assert_seed_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_wr && word_full) |=> (st_q.seed == $past(bus_wdata)));

    assert_no_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ($stable(st_q.crc) && $stable(st_q.poly) && $stable(st_q.seed)));
endmodule

// File: tb/crc_mmio_unit_tb.sv
module crc_mmio_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_errs = 0;

    logic [31:0] m_crc = 32'hFFFF_FFFF, m_seed = 32'hFFFF_FFFF, m_poly = 32'h04C1_1DB7;
    int          m_mode = 0;
    logic        m_orev = 1'b0;
    logic [31:0] rnd = 32'h1357_9BDF;

    always #10 clk = ~clk;

    crc_mmio_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] m_rev(input logic [31:0] x, input int g);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) r[(i/g)*g + g - 1 - (i%g)] = x[i];
        return r;
    endfunction

    function automatic logic [31:0] m_fold(input logic [31:0] c, input logic [31:0] p,
                                           input logic [31:0] d, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            logic fb;
            fb = c[31] ^ d[i];
            c = {c[30:0], 1'b0} ^ (fb ? p : 32'h0);
        end
        return c;
    endfunction

    function automatic logic [31:0] m_view();
        return m_orev ? m_rev(m_crc, 32) : m_crc;
    endfunction

    task automatic next_rnd();
        rnd = rnd * 32'd1103515245 + 32'd12345;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_ctrl(input logic [31:0] v);
        bus_write(5'h08, v, 4'hF);
        m_mode = int'(v[6:5]);
        m_orev = v[7];
        if (v[0]) m_crc = m_seed;
    endtask

    task automatic put_word(input logic [31:0] w);
        logic [31:0] s;
        bus_write(5'h00, w, 4'hF);
        s = (m_mode == 0) ? w : m_rev(w, (m_mode == 1) ? 8 : (m_mode == 2) ? 16 : 32);
        m_crc = m_fold(m_crc, m_poly, s, 32);
    endtask

    task automatic put_byte(input int lane, input logic [7:0] b);
        logic [31:0] w;
        logic [31:0] s;
        next_rnd();
        w = rnd;
        w[lane*8 +: 8] = b;
        bus_write(5'h00, w, 4'(1 << lane));
        s = {24'h0, b};
        if (m_mode != 0) s = m_rev(s, 8);
        m_crc = m_fold(m_crc, m_poly, s, 8);
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin : stim
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(5'h10, r); check("R1 seed", r, 32'hFFFF_FFFF);
        bus_read(5'h14, r); check("R1 poly", r, 32'h04C1_1DB7);
        bus_read(5'h08, r); check("R1 ctrl", r, 32'h0);
        bus_read(5'h00, r); check("R1 data", r, 32'hFFFF_FFFF);

        // R2 register map and lane masking
        bus_write(5'h10, 32'h1234_5678, 4'hF); m_seed = 32'h1234_5678;
        bus_read(5'h10, r); check("R2 seed readback", r, 32'h1234_5678);
        bus_write(5'h14, 32'hAAAA_5555, 4'b0011); m_poly = 32'h04C1_5555;
        bus_read(5'h14, r); check("R2 poly lane mask", r, 32'h04C1_5555);
        bus_write(5'h04, 32'hDEAD_BEEF, 4'hF);
        bus_read(5'h04, r); check("R2 unmapped offset", r, 32'h0);

        // R3 / R11 restart and readback through output reversal
        set_ctrl(32'h0000_0001);
        bus_read(5'h00, r); check("R11 restart plain", r, 32'h1234_5678);
        set_ctrl(32'h0000_0081);
        bus_read(5'h00, r); check("R11 restart reversed", r, m_rev(32'h1234_5678, 32));
        bus_read(5'h08, r); check("R3 restart bit reads 0", r, 32'h0000_0080);

        // R4 R5 R6 R7 sweep over shaping modes and output setting
        for (int mode = 0; mode < 4; mode++) begin
            for (int orev = 0; orev < 2; orev++) begin
                next_rnd(); bus_write(5'h14, rnd, 4'hF); m_poly = rnd;
                next_rnd(); bus_write(5'h10, rnd, 4'hF); m_seed = rnd;
                set_ctrl(32'(mode << 5) | 32'(orev << 7) | 32'h1);
                bus_read(5'h08, r); check("R7 ctrl readback", r, 32'(mode << 5) | 32'(orev << 7));
                bus_read(5'h00, r); check("R11 seed view", r, m_view());
                for (int k = 0; k < 4; k++) begin
                    next_rnd(); put_word(rnd);
                    bus_read(5'h00, r); check("R4 R6 R7 word fold", r, m_view());
                end
                for (int lane = 0; lane < 4; lane++) begin
                    next_rnd(); put_byte(lane, rnd[15:8]);
                    bus_read(5'h00, r); check("R5 R6 byte lane fold", r, m_view());
                end
                foreach (r[i]) begin end
                next_rnd(); bus_write(5'h00, rnd, 4'b0000);
                bus_read(5'h00, r); check("R5 no strobe ignored", r, m_view());
                next_rnd(); bus_write(5'h00, rnd, 4'b0011);
                bus_read(5'h00, r); check("R5 two strobes ignored", r, m_view());
                next_rnd(); bus_write(5'h00, rnd, 4'b1110);
                bus_read(5'h00, r); check("R5 three strobes ignored", r, m_view());
                // R8 switch config without restart
                set_ctrl(32'((3 - mode) << 5) | 32'(orev << 7));
                bus_read(5'h00, r); check("R8 config switch keeps crc", r, m_view());
            end
        end

        // R10 back-to-back word writes
        set_ctrl(32'h0000_0001);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'h00; bus_be = 4'hF; bus_wdata = 32'hCAFE_F00D;
        @(negedge clk);
        bus_wdata = 32'h0BAD_1DEA;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
        m_crc = m_fold(m_crc, m_poly, 32'hCAFE_F00D, 32);
        m_crc = m_fold(m_crc, m_poly, 32'h0BAD_1DEA, 32);
        bus_read(5'h00, r); check("R10 back-to-back", r, m_view());

        // R9 standard check values
        bus_write(5'h10, 32'hFFFF_FFFF, 4'hF); m_seed = 32'hFFFF_FFFF;
        bus_write(5'h14, 32'h04C1_1DB7, 4'hF); m_poly = 32'h04C1_1DB7;
        set_ctrl(32'h0000_00A1);
        for (int c = 8'h31; c <= 8'h39; c++) put_byte(0, 8'(c));
        bus_read(5'h00, r); check("R9 crc32 check value", ~r, 32'hCBF4_3926);

        bus_write(5'h14, 32'h1EDC_6F41, 4'hF); m_poly = 32'h1EDC_6F41;
        set_ctrl(32'h0000_00E1);
        put_word(32'h3433_3231);
        put_word(32'h3837_3635);
        set_ctrl(32'h0000_00A0);
        put_byte(0, 8'h39);
        bus_read(5'h00, r); check("R9 crc32c check value", ~r, 32'hE306_9283);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule